// File: doc/BRIEF.md
# Write-Protect Aware Write Commit Controller

This block sits between the serial slave front end of a small non-volatile memory and its storage array. The front end hands over each received data byte together with the address it targets, a strobe marking the clock edge that samples the first data bit of a write, a strobe for a stop condition and a strobe for a repeated start. The controller buffers the bytes and commits them to the array only when a stop ends the transfer. It then runs a timed internal program cycle and reports itself busy for the whole of that cycle.

The write-protect pin is watched continuously from the first data bit until the internal cycle ends. Raising it during the receive phase cancels the pending write outright. Raising it while the program cycle is running aborts that cycle at once. The addresses being programmed are then left holding a fixed poison pattern, so that the model shows their contents as undefined. The pin passes through a two-flop synchroniser before any decision uses it.

Top module: `wp_write_commit`

## Requirements
- R1: After reset, `busy` and `mem_we` are low and no array write occurs until a full write transaction has been received.
- R2: Bytes received after `first_bit_stb` and followed by `stop_stb` are written to the array one per `mem_we` cycle, in arrival order, each at the address delivered with it. The first strobe comes WR_CYCLES clock cycles after the edge that accepts the stop.
- R3: `busy` rises on the clock edge that accepts a stop with at least one buffered byte. It stays high for exactly WR_CYCLES + N cycles, where N is the number of buffered bytes, and it is high whenever `mem_we` is high.
- R4: A `restart_stb` received before any stop discards the buffered bytes, and no array write results from them.
- R5: When the synchronised protect pin is high while bytes are being received, the write is cancelled. No array write occurs, and bytes or a stop arriving afterwards are ignored until the next `first_bit_stb`.
- R6: When the synchronised protect pin goes high during the program cycle, the cycle ends early. Every buffered address is then written once, in order, with the POISON value (default 0xA5) in place of its data.
- R7: Bytes and stops that arrive before `first_bit_stb` opens a transaction have no effect.
- R8: At most DEPTH bytes are buffered per transaction. Any further bytes are dropped and the first DEPTH are written.
- R9: A stop that arrives with no buffered byte starts no program cycle: `busy` stays low and nothing is written.
- R10: While `busy` is high, incoming first-bit, byte and stop strobes are ignored and produce no further write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_pin | input | 1 | Asynchronous write-protect pin, high protects |
| first_bit_stb | input | 1 | Pulse on the edge sampling the first data bit of a write |
| byte_stb | input | 1 | Pulse: a data byte is valid on byte_addr/byte_data |
| byte_addr | input | 13 | Array address for the received byte |
| byte_data | input | 8 | Received data byte |
| stop_stb | input | 1 | Pulse: stop condition seen |
| restart_stb | input | 1 | Pulse: repeated start seen (transaction ends without stop) |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 13 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Program cycle in progress |

## Verification
The bench aims at the timing edges of the protect window. It raises the pin during reception, and a design that missed this would still program the bytes. It raises the pin during the program cycle, and a design that let the cycle run to the end would write real data where poison belongs. It ends a transfer with a repeated start instead of a stop, and overfills the buffer, which a design with wrong limits would corrupt or overrun. It also measures the exact length of the busy period and sends strobes while the block is busy, so that an off-by-one timer or an FSM that re-arms early shows up as a wrong busy length or an extra write.

// File: rtl/wcc_pkg.sv
package wcc_pkg;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    // One buffered write: target address and byte value.
    typedef struct packed {
        addr_t addr;
        data_t data;
    } wr_item_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PROGRAM = 2'd2,
        ST_FLUSH   = 2'd3
    } ctl_state_t;

    function automatic data_t pick_data(input wr_item_t it, input logic poison,
                                        input data_t pattern);
        return poison ? pattern : it.data;
    endfunction

endpackage

// File: rtl/wcc_wp_sync.sv
module wcc_wp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/wcc_byte_buf.sv
module wcc_byte_buf
    import wcc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         push,
    input  wr_item_t                     push_item,
    input  logic                         pop,
    output wr_item_t                     head_item,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    wr_item_t           store [DEPTH];
    logic [IDX_W-1:0]   wr_ptr, rd_ptr;
    logic               do_push, do_pop;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (count < CNT_W'(DEPTH));
    assign do_pop  = pop && (count != '0);

    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= push_item;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    assign head_item = store[rd_ptr];

    // R8: occupancy never exceeds the configured depth
    a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R2: the controller only drains entries that exist
    a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));
endmodule

// File: rtl/wcc_cycle_timer.sv
module wcc_cycle_timer #(
    parameter int CYCLES = 500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic kill,
    output logic running,
    output logic done
);
    localparam int CW = $clog2(CYCLES+1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            running <= 1'b0;
            remain  <= '0;
        end else if (start) begin
            running <= 1'b1;
            remain  <= CW'(CYCLES-1);
        end else if (running) begin
            if (remain == '0) running <= 1'b0;
            else              remain  <= remain - 1'b1;
        end
    end

    assign done = running && (remain == '0);

    // R3: completion is a single-cycle event
    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/wp_write_commit.sv
module wp_write_commit #(
    parameter int                          DEPTH     = 8,
    parameter int                          WR_CYCLES = 500_000,
    parameter logic [wcc_pkg::DATA_W-1:0]  POISON    = 8'hA5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wp_pin,
    input  logic                        first_bit_stb,
    input  logic                        byte_stb,
    input  logic [wcc_pkg::ADDR_W-1:0]  byte_addr,
    input  logic [wcc_pkg::DATA_W-1:0]  byte_data,
    input  logic                        stop_stb,
    input  logic                        restart_stb,
    output logic                        mem_we,
    output logic [wcc_pkg::ADDR_W-1:0]  mem_addr,
    output logic [wcc_pkg::DATA_W-1:0]  mem_wdata,
    output logic                        busy
);
    import wcc_pkg::*;

    localparam int CNT_W = $clog2(DEPTH+1);

    ctl_state_t         state, state_nx;
    logic               poison_q, poison_nx;
    logic               wp_s;
    logic               buf_clear, buf_push, buf_pop;
    wr_item_t           in_item, head;
    logic [CNT_W-1:0]   buf_count;
    logic               tmr_start, tmr_kill, tmr_running, tmr_done;

    wcc_wp_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d_async(wp_pin), .q_sync(wp_s)
    );

    assign in_item = '{addr: byte_addr, data: byte_data};

    wcc_byte_buf #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst(rst), .clear(buf_clear), .push(buf_push),
        .push_item(in_item), .pop(buf_pop), .head_item(head), .count(buf_count)
    );

    wcc_cycle_timer #(.CYCLES(WR_CYCLES)) u_tmr (
        .clk(clk), .rst(rst), .start(tmr_start), .kill(tmr_kill),
        .running(tmr_running), .done(tmr_done)
    );

    always_comb begin
        state_nx  = state;
        poison_nx = poison_q;
        buf_clear = 1'b0;
        buf_push  = 1'b0;
        buf_pop   = 1'b0;
        tmr_start = 1'b0;
        tmr_kill  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (first_bit_stb) state_nx = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (wp_s || restart_stb) begin
                    buf_clear = 1'b1;
                    state_nx  = ST_IDLE;
                end else if (stop_stb) begin
                    if (buf_count != '0) begin
                        tmr_start = 1'b1;
                        poison_nx = 1'b0;
                        state_nx  = ST_PROGRAM;
                    end else begin
                        state_nx  = ST_IDLE;
                    end
                end else if (byte_stb) begin
                    buf_push = 1'b1;
                end
            end
            ST_PROGRAM: begin
                if (wp_s) begin
                    tmr_kill  = 1'b1;
                    poison_nx = 1'b1;
                    state_nx  = ST_FLUSH;
                end else if (tmr_done) begin
                    state_nx  = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                buf_pop = 1'b1;
                if (buf_count <= CNT_W'(1)) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            poison_q <= 1'b0;
        end else begin
            state    <= state_nx;
            poison_q <= poison_nx;
        end
    end

    assign mem_we    = (state == ST_FLUSH);
    assign mem_addr  = head.addr;
    assign mem_wdata = pick_data(head, poison_q, POISON);
    assign busy      = (state == ST_PROGRAM) || (state == ST_FLUSH);

    // R3: array strobes only inside the busy period
    a_r3_we_while_busy: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R3: program state always has a live timer behind it
    a_r3_timer_live: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROGRAM) |-> tmr_running);

    // R5: a protect hit during reception empties the buffer
    a_r5_cancel_empties: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COLLECT && wp_s) |=> (buf_count == '0));

    // R6: after an abort, any strobe carries the poison value
    a_r6_abort_poison: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROGRAM && wp_s) |=> (mem_we && mem_wdata == POISON));

    // R9: a stop with nothing buffered starts no cycle
    a_r9_empty_stop: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COLLECT && !wp_s && !restart_stb && stop_stb && buf_count == '0)
        |=> !busy);
endmodule

// File: tb/wp_write_commit_tb_top.sv
module wp_write_commit_tb_top;

    localparam int W     = 20;
    localparam int DEPTH = 4;
    localparam logic [7:0] PZN = 8'hEE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wp_pin = 1'b0;
    logic        first_bit_stb = 1'b0;
    logic        byte_stb = 1'b0;
    logic [12:0] byte_addr = '0;
    logic [7:0]  byte_data = '0;
    logic        stop_stb = 1'b0;
    logic        restart_stb = 1'b0;
    logic        mem_we;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int writes_seen = 0;
    int busy_run = 0;
    int last_busy_len = 0;
    int busy_periods = 0;
    string cur_req = "R1";
    logic [20:0] exp_q[$];

    always #5 clk = ~clk;

    wp_write_commit #(.DEPTH(DEPTH), .WR_CYCLES(W), .POISON(PZN)) dut_i (
        .clk(clk), .rst(rst), .wp_pin(wp_pin), .first_bit_stb(first_bit_stb),
        .byte_stb(byte_stb), .byte_addr(byte_addr), .byte_data(byte_data),
        .stop_stb(stop_stb), .restart_stb(restart_stb), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard of array writes and busy-period lengths
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            writes_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, {mem_addr, mem_wdata}, 0);
            end else begin
                logic [20:0] e;
                e = exp_q.pop_front();
                check({mem_addr, mem_wdata} == e, cur_req, {mem_addr, mem_wdata}, e);
            end
        end
        if (!rst && busy) busy_run++;
        else if (busy_run != 0) begin
            last_busy_len = busy_run;
            busy_run = 0;
            busy_periods++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic pulse_first();
        first_bit_stb = 1'b1; @(negedge clk); first_bit_stb = 1'b0;
    endtask
    task automatic send_byte(input logic [12:0] a, input logic [7:0] d);
        byte_stb = 1'b1; byte_addr = a; byte_data = d;
        @(negedge clk); byte_stb = 1'b0;
    endtask
    task automatic send_stop();
        stop_stb = 1'b1; @(negedge clk); stop_stb = 1'b0;
    endtask
    task automatic send_restart();
        restart_stb = 1'b1; @(negedge clk); restart_stb = 1'b0;
    endtask
    task automatic expect_wr(input logic [12:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int w0, p0;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1: reset state
        check(busy == 1'b0, "R1", busy, 0);
        check(mem_we == 1'b0, "R1", mem_we, 0);

        // R2/R3: normal three-byte commit
        cur_req = "R2";
        w0 = writes_seen; p0 = busy_periods;
        pulse_first();
        send_byte(13'h0010, 8'h11); expect_wr(13'h0010, 8'h11);
        send_byte(13'h0011, 8'h22); expect_wr(13'h0011, 8'h22);
        send_byte(13'h0012, 8'h33); expect_wr(13'h0012, 8'h33);
        send_stop();
        check(busy == 1'b1, "R3", busy, 1);
        tick(W - 1);
        check(mem_we == 1'b0, "R2", mem_we, 0);
        tick(1);
        check(mem_we == 1'b1, "R2", mem_we, 1);
        tick(W);
        check(writes_seen - w0 == 3, "R2", writes_seen - w0, 3);
        check(busy_periods - p0 == 1, "R3", busy_periods - p0, 1);
        check(last_busy_len == W + 3, "R3", last_busy_len, W + 3);

        // R4: restart instead of stop
        cur_req = "R4";
        w0 = writes_seen;
        pulse_first();
        send_byte(13'h0100, 8'h44);
        send_byte(13'h0101, 8'h55);
        send_restart();
        send_stop();
        tick(W + 10);
        check(writes_seen == w0, "R4", writes_seen - w0, 0);
        check(busy == 1'b0, "R4", busy, 0);

        // R5: protect high during reception
        cur_req = "R5";
        w0 = writes_seen; p0 = busy_periods;
        pulse_first();
        send_byte(13'h0200, 8'h66);
        wp_pin = 1'b1;
        tick(4);
        wp_pin = 1'b0;
        tick(4);
        send_byte(13'h0201, 8'h77);
        send_stop();
        tick(W + 10);
        check(writes_seen == w0, "R5", writes_seen - w0, 0);
        check(busy_periods == p0, "R5", busy_periods - p0, 0);

        // R6: protect high during the program cycle
        cur_req = "R6";
        w0 = writes_seen;
        pulse_first();
        send_byte(13'h0300, 8'h12); expect_wr(13'h0300, PZN);
        send_byte(13'h1FFF, 8'h34); expect_wr(13'h1FFF, PZN);
        send_stop();
        tick(5);
        wp_pin = 1'b1;
        tick(10);
        check(busy == 1'b0, "R6", busy, 0);
        wp_pin = 1'b0;
        tick(W);
        check(writes_seen - w0 == 2, "R6", writes_seen - w0, 2);

        // R7: traffic before the window opens
        cur_req = "R7";
        w0 = writes_seen;
        send_byte(13'h0400, 8'h99);
        send_stop();
        tick(3);
        check(busy == 1'b0, "R7", busy, 0);
        pulse_first();
        send_byte(13'h0401, 8'hAB); expect_wr(13'h0401, 8'hAB);
        send_stop();
        tick(W + 8);
        check(writes_seen - w0 == 1, "R7", writes_seen - w0, 1);

        // R8: overfill the buffer
        cur_req = "R8";
        w0 = writes_seen;
        pulse_first();
        for (int i = 0; i < DEPTH + 2; i++) begin
            send_byte(13'h0500 + 13'(i), 8'hC0 + 8'(i));
            if (i < DEPTH) expect_wr(13'h0500 + 13'(i), 8'hC0 + 8'(i));
        end
        send_stop();
        tick(W + DEPTH + 5);
        check(writes_seen - w0 == DEPTH, "R8", writes_seen - w0, DEPTH);
        check(last_busy_len == W + DEPTH, "R8", last_busy_len, W + DEPTH);

        // R9: stop with empty buffer
        cur_req = "R9";
        p0 = busy_periods;
        pulse_first();
        send_stop();
        check(busy == 1'b0, "R9", busy, 0);
        tick(W);
        check(busy_periods == p0, "R9", busy_periods - p0, 0);

        // R10: strobes while busy are ignored
        cur_req = "R10";
        w0 = writes_seen; p0 = busy_periods;
        pulse_first();
        send_byte(13'h0600, 8'h5A); expect_wr(13'h0600, 8'h5A);
        send_stop();
        tick(3);
        pulse_first();
        send_byte(13'h0601, 8'hA5);
        send_stop();
        tick(2 * W + 10);
        check(writes_seen - w0 == 1, "R10", writes_seen - w0, 1);
        check(busy_periods - p0 == 1, "R10", busy_periods - p0, 1);
        check(last_busy_len == W + 1, "R10", last_busy_len, W + 1);
        check(exp_q.size() == 0, "R2", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule